// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits on the host side of a parallel NOR-style flash that has an asynchronous read interface. A client sends one read at a time over a valid/ready request port. Each request carries a byte address and a flag that selects byte or word width. The controller drives the chip-enable, output-enable, write-enable, width-select and address pins. It then holds them for a programmed number of clock cycles, samples the data bus at the end of that wait, and returns the result as a one-cycle response pulse.

The flash has pages of eight words (sixteen bytes). After a full random access has opened a page, later reads inside that page need only the short page access time, provided chip enable stays low. The controller remembers the open page, and the width mode used to open it, in a tag. A read that matches the tag waits the short count. Any other read waits the long count. When no request arrives for a programmed number of idle cycles, the controller releases chip enable and drops the tag. A flag on each response reports which of the two waits was applied.

Top module: `pgflash_rd_ctrl`

## Requirements
- R1: After reset, `fl_ce_n` and `fl_oe_n` are 1, `req_ready` is 1 and `rsp_valid` is 0. `fl_we_n` is 1 at all times. During an access, `fl_ce_n` and `fl_oe_n` are both 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the cycle in which `rsp_valid` is 1. Only one read is in flight at a time.
- R3: A read that is not a page hit holds its pins for `cfg_tacc` cycles. `rsp_valid` rises at the `cfg_tacc`-th rising edge after the accepting edge, with `rsp_hit` = 0.
- R4: A read is a page hit when chip enable has stayed low since the previous access, byte-address bits [BADDR_W-1:4] equal those of the page last opened, and the width mode is unchanged. A hit waits `cfg_tpacc` cycles instead, with `rsp_hit` = 1.
- R5: Word mode (`req_byte` = 0) drives `fl_byte_n` = 1, `fl_addr` = `req_addr[BADDR_W-1:1]` and `fl_alsb` = 0, and returns all 16 bits of `fl_dq`. Address bit 0 has no effect.
- R6: Byte mode (`req_byte` = 1) drives `fl_byte_n` = 0 and `fl_alsb` = `req_addr[0]`, and returns `{8'h00, fl_dq[7:0]}`.
- R7: A read whose width mode differs from the mode of the open page is treated as a miss, even inside the same sixteen-byte page.
- R8: When `cfg_idle` = K > 0, chip enable is low, and K consecutive idle cycles pass with no request taken, `fl_ce_n` becomes 1 at the end of the K-th cycle. The open page is then forgotten, so the next read is a miss. K = 0 keeps chip enable low indefinitely.
- R9: A request taken in the K-th idle cycle has priority over the timeout. Chip enable stays low, and the read is a hit if it falls in the open page.
- R10: A wait count of 0 in `cfg_tacc` or `cfg_tpacc` behaves as 1.
- R11: `rsp_valid` is a single-cycle pulse. `rsp_hit` in that cycle reports which wait was used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tacc | input | CNT_W | Full random access wait, in cycles |
| cfg_tpacc | input | CNT_W | In-page access wait, in cycles |
| cfg_idle | input | IDLE_W | Idle cycles before chip enable is released (0 = never) |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | BADDR_W | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle pulse: response data valid |
| rsp_data | output | DATA_W | Read result |
| rsp_hit | output | 1 | 1 when the short in-page wait was used |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, held high |
| fl_byte_n | output | 1 | Flash width select, 0 = byte mode |
| fl_addr | output | BADDR_W-1 | Flash word address |
| fl_alsb | output | 1 | Byte-select address bit below the word address |
| fl_dq | input | DATA_W | Flash data bus |

## Verification
Two events can land on the same clock edge: the idle timeout expiring and a new request being accepted. The bench provokes this by finishing a read and then waiting exactly `cfg_idle` - 1 further cycles before issuing a read to the same page. That read must come back as a hit with the short latency, and chip enable must not have risen. One cycle later the opposite case applies: chip enable must already be high, and the next read to that page must be a miss. The flash model outputs garbage unless the page timing it sees on the pins was actually honoured, so a wrong wait also shows up as wrong data.

// File: rtl/pgflash_pkg.sv
package pgflash_pkg;

    // Sequencer state of the read controller.
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } rd_state_e;

    // Width of one byte lane on the flash data bus.
    localparam int LANE_W = 8;

endpackage

// File: rtl/pgflash_wait_timer.sv
module pgflash_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            // A zero wait is stretched to one cycle (R10).
            cnt_d = (load_val == '0) ? ONE : load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == ONE);

    a_r10_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));

endmodule

// File: rtl/pgflash_page_tag.sv
module pgflash_page_tag #(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              load_mode,
    input  logic              drop,
    input  logic [PAGE_W-1:0] q_page,
    input  logic              q_mode,
    output logic              hit
);

    typedef struct packed {
        logic              valid;
        logic              mode;
        logic [PAGE_W-1:0] page;
    } tag_t;

    tag_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (drop) begin
            t_d.valid = 1'b0;
        end else if (load_en) begin
            t_d.valid = 1'b1;
            t_d.page  = load_page;
            t_d.mode  = load_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // Hit needs same page and same width mode (R4, R7).
    assign hit = t_q.valid && (t_q.page == q_page) && (t_q.mode == q_mode);

    a_r9_no_load_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && drop));

endmodule

// File: rtl/pgflash_idle_timer.sv
module pgflash_idle_timer #(
    parameter int IDLE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [IDLE_W-1:0] limit,
    output logic              expire
);

    localparam int EXT_W = IDLE_W + 1;

    logic [IDLE_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0]  next_cnt;

    assign next_cnt = {1'b0, cnt_q} + EXT_W'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || restart) begin
            cnt_d = '0;
        end else if (cnt_q != '1) begin
            cnt_d = cnt_q + IDLE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // An accepted request in the same cycle beats the timeout (R9).
    assign expire = run && !restart && (limit != '0) &&
                    (next_cnt == {1'b0, limit});

endmodule

// File: rtl/pgflash_rd_ctrl.sv
module pgflash_rd_ctrl #(
    parameter int BADDR_W    = 24,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 8,
    parameter int IDLE_W     = 12,
    parameter int PAGE_WORDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_tacc,
    input  logic [CNT_W-1:0]   cfg_tpacc,
    input  logic [IDLE_W-1:0]  cfg_idle,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BADDR_W-1:0] req_addr,
    input  logic               req_byte,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_hit,
    output logic               fl_ce_n,
    output logic               fl_oe_n,
    output logic               fl_we_n,
    output logic               fl_byte_n,
    output logic [BADDR_W-2:0] fl_addr,
    output logic               fl_alsb,
    input  logic [DATA_W-1:0]  fl_dq
);

    import pgflash_pkg::*;

    localparam int WADDR_W  = BADDR_W - 1;
    localparam int WOFF_W   = $clog2(PAGE_WORDS);
    localparam int PAGE_LSB = WOFF_W + 1;
    localparam int PAGE_W   = BADDR_W - PAGE_LSB;

    typedef struct packed {
        rd_state_e          state;
        logic               ce_n;
        logic               oe_n;
        logic               byte_n;
        logic               alsb;
        logic               hit;
        logic               rsp_valid;
        logic               rsp_hit;
        logic [WADDR_W-1:0] addr;
        logic [DATA_W-1:0]  rsp_data;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        state:     ST_IDLE,
        ce_n:      1'b1,
        oe_n:      1'b1,
        byte_n:    1'b1,
        alsb:      1'b0,
        hit:       1'b0,
        rsp_valid: 1'b0,
        rsp_hit:   1'b0,
        addr:      '0,
        rsp_data:  '0
    };

    ctrl_t s_d, s_q;

    logic              accept;
    logic              tag_hit;
    logic              wait_done;
    logic              idle_run;
    logic              idle_expire;
    logic [CNT_W-1:0]  wait_val;
    logic [PAGE_W-1:0] req_page;
    logic [DATA_W-1:0] capture;

    assign accept   = req_valid && (s_q.state == ST_IDLE);
    assign idle_run = (s_q.state == ST_IDLE) && !s_q.ce_n;
    assign req_page = req_addr[BADDR_W-1:PAGE_LSB];
    assign wait_val = tag_hit ? cfg_tpacc : cfg_tacc;

    // Byte mode returns only the low lane, zero-extended (R6).
    assign capture = s_q.byte_n ? fl_dq : DATA_W'(fl_dq[LANE_W-1:0]);

    pgflash_page_tag #(
        .PAGE_W (PAGE_W)
    ) i_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept),
        .load_page (req_page),
        .load_mode (req_byte),
        .drop      (idle_expire),
        .q_page    (req_page),
        .q_mode    (req_byte),
        .hit       (tag_hit)
    );

    pgflash_wait_timer #(
        .CNT_W (CNT_W)
    ) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_val),
        .done     (wait_done)
    );

    pgflash_idle_timer #(
        .IDLE_W (IDLE_W)
    ) i_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (idle_run),
        .restart (accept),
        .limit   (cfg_idle),
        .expire  (idle_expire)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (accept) begin
                    s_d.state  = ST_ACCESS;
                    s_d.ce_n   = 1'b0;
                    s_d.oe_n   = 1'b0;
                    s_d.byte_n = ~req_byte;
                    s_d.alsb   = req_byte & req_addr[0];
                    s_d.addr   = req_addr[BADDR_W-1:1];
                    s_d.hit    = tag_hit;
                end else if (idle_expire) begin
                    s_d.ce_n   = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (wait_done) begin
                    s_d.state     = ST_IDLE;
                    s_d.oe_n      = 1'b1;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_hit   = s_q.hit;
                    s_d.rsp_data  = capture;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTRL_RESET;
        else        s_q <= s_d;
    end

    assign req_ready = (s_q.state == ST_IDLE);
    assign rsp_valid = s_q.rsp_valid;
    assign rsp_data  = s_q.rsp_data;
    assign rsp_hit   = s_q.rsp_hit;
    assign fl_ce_n   = s_q.ce_n;
    assign fl_oe_n   = s_q.oe_n;
    assign fl_we_n   = 1'b1;
    assign fl_byte_n = s_q.byte_n;
    assign fl_addr   = s_q.addr;
    assign fl_alsb   = s_q.alsb;

    a_r1_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_ce_n);

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n && !rsp_valid) |-> !req_ready);

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n && $past(!fl_oe_n)) |-> ($stable(fl_addr) && $stable(fl_alsb)));

    a_r4_hit_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        tag_hit |-> !fl_ce_n);

    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_pgflash_rd_ctrl.sv
module test_pgflash_rd_ctrl;

    localparam int BADDR_W = 24;
    localparam int DATA_W  = 16;
    localparam int CNT_W   = 8;
    localparam int IDLE_W  = 12;
    localparam int NV      = 11;
    localparam int IDLE_K  = 8;

    // {byte mode, byte address, expected hit}
    localparam logic [25:0] VECS [0:NV-1] = '{
        {1'b0, 24'h000100, 1'b0},
        {1'b0, 24'h000102, 1'b1},
        {1'b0, 24'h00010E, 1'b1},
        {1'b0, 24'h000110, 1'b0},
        {1'b0, 24'h000112, 1'b1},
        {1'b1, 24'h000113, 1'b0},
        {1'b1, 24'h000110, 1'b1},
        {1'b1, 24'h00011F, 1'b1},
        {1'b0, 24'h000110, 1'b0},
        {1'b0, 24'h000111, 1'b1},
        {1'b0, 24'h002000, 1'b0}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic [CNT_W-1:0]   cfg_tacc, cfg_tpacc;
    logic [IDLE_W-1:0]  cfg_idle;
    logic               req_valid, req_ready, req_byte;
    logic [BADDR_W-1:0] req_addr;
    logic               rsp_valid, rsp_hit;
    logic [DATA_W-1:0]  rsp_data;
    logic               fl_ce_n, fl_oe_n, fl_we_n, fl_byte_n, fl_alsb;
    logic [BADDR_W-2:0] fl_addr;
    logic [DATA_W-1:0]  fl_dq;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;

    pgflash_rd_ctrl #(
        .BADDR_W (BADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W), .IDLE_W (IDLE_W)
    ) i_pgflash_rd_ctrl (
        .clk (clk), .rst_n (rst_n),
        .cfg_tacc (cfg_tacc), .cfg_tpacc (cfg_tpacc), .cfg_idle (cfg_idle),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_byte (req_byte),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_hit (rsp_hit),
        .fl_ce_n (fl_ce_n), .fl_oe_n (fl_oe_n), .fl_we_n (fl_we_n),
        .fl_byte_n (fl_byte_n), .fl_addr (fl_addr), .fl_alsb (fl_alsb),
        .fl_dq (fl_dq)
    );

    function automatic logic [15:0] mem_word(input logic [22:0] wa);
        return (wa[15:0] * 16'h9E37) ^ 16'h5A3C;
    endfunction

    // Behavioural flash: data is valid only if the pin timing was honoured.
    int eff_acc, eff_pacc;
    always_comb eff_acc  = (cfg_tacc  == '0) ? 1 : int'(cfg_tacc);
    always_comb eff_pacc = (cfg_tpacc == '0) ? 1 : int'(cfg_tpacc);

    logic [26:0] sig_last = '1;
    logic [20:0] pg_last  = '1;
    int          stable   = 0;
    logic        popen    = 1'b0;

    always @(negedge clk) begin
        logic [26:0] sig;
        logic [20:0] pg;
        sig = {fl_ce_n, fl_oe_n, fl_byte_n, fl_alsb, fl_addr};
        pg  = {fl_byte_n, fl_addr[22:3]};
        if (sig != sig_last) begin
            if (pg != pg_last) popen = 1'b0;
            stable = 1;
        end else if (stable < 1000) begin
            stable++;
        end
        if (fl_ce_n) popen = 1'b0;
        else if (!fl_oe_n && stable >= eff_acc) popen = 1'b1;
        sig_last = sig;
        pg_last  = pg;
    end

    logic [15:0] mdl_w;
    assign mdl_w = mem_word(fl_addr);
    assign fl_dq = (!fl_ce_n && !fl_oe_n &&
                    (stable >= eff_acc || (popen && stable >= eff_pacc)))
                   ? (fl_byte_n ? mdl_w : {8'hEE, (fl_alsb ? mdl_w[15:8] : mdl_w[7:0])})
                   : 16'hDEAD;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Issue one read from a negedge; returns at the negedge that shows rsp_valid.
    task automatic do_read(input logic bm, input logic [23:0] a,
                           input logic eh, input string rq);
        int lat;
        bit first;
        logic [15:0] w, ed;
        string mrq;
        mrq = bm ? "R6" : "R5";
        check(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_byte = bm; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        lat = 0; first = 1'b1;
        forever begin
            @(negedge clk);
            if (rsp_valid) break;
            lat++;
            if (first) begin
                check(fl_ce_n == 1'b0 && fl_oe_n == 1'b0, "R1", "ce/oe low in access",
                      {fl_ce_n, fl_oe_n}, 0);
                check(fl_byte_n == !bm && fl_alsb == (bm & a[0]) && fl_addr == a[23:1],
                      mrq, "pins", {fl_byte_n, fl_alsb, 6'd0, fl_addr},
                      {!bm, (bm & a[0]), 6'd0, a[23:1]});
                first = 1'b0;
            end
            if (req_ready) check(1'b0, "R2", "ready during access", 1, 0);
            if (lat > 300) break;
        end
        w  = mem_word(a[23:1]);
        ed = bm ? {8'h00, (a[0] ? w[15:8] : w[7:0])} : w;
        check(rsp_data == ed, mrq, "read data", rsp_data, ed);
        check(rsp_hit == eh, (rq == "") ? "R11" : rq, "rsp_hit", rsp_hit, eh);
        check(lat == (eh ? eff_pacc : eff_acc), (rq == "") ? (eh ? "R4" : "R3") : rq,
              "latency", lat, eh ? eff_pacc : eff_acc);
        check(fl_we_n == 1'b1, "R1", "we_n high", fl_we_n, 1);
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_total);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_byte = 1'b0; req_addr = '0;
        cfg_tacc = 8'd6; cfg_tpacc = 8'd2; cfg_idle = IDLE_K;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(fl_ce_n && fl_oe_n && fl_we_n, "R1", "pins in reset",
              {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/valid in reset",
              {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 misses, R4 hits, R5/R6 widths, R7 mode switches
        for (int i = 0; i < NV; i++) begin
            do_read(VECS[i][25], VECS[i][24:1], VECS[i][0],
                    VECS[i][0] ? "R4" : ((i == 5 || i == 8) ? "R7" : "R3"));
        end

        // R9: request in the K-th idle cycle beats the timeout
        do_read(1'b0, 24'h003000, 1'b0, "R3");
        repeat (IDLE_K - 1) @(negedge clk);
        check(fl_ce_n == 1'b0, "R9", "ce still low before expiry", fl_ce_n, 0);
        do_read(1'b0, 24'h003004, 1'b1, "R9");

        // R8: expiry after K idle cycles, then a miss on the same page
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11", "rsp pulse one cycle", rsp_valid, 0);
        repeat (IDLE_K - 2) @(negedge clk);
        check(fl_ce_n == 1'b0, "R8", "ce low at idle cycle K", fl_ce_n, 0);
        @(negedge clk);
        check(fl_ce_n == 1'b1, "R8", "ce released after K idle", fl_ce_n, 1);
        do_read(1'b0, 24'h003006, 1'b0, "R8");

        // R8: K = 0 disables the timeout
        cfg_idle = '0;
        do_read(1'b0, 24'h004000, 1'b0, "R3");
        repeat (40) @(negedge clk);
        check(fl_ce_n == 1'b0, "R8", "ce held with timeout off", fl_ce_n, 0);
        do_read(1'b0, 24'h004008, 1'b1, "R8");

        // R10: zero waits behave as one cycle
        cfg_tpacc = '0;
        do_read(1'b1, 24'h00400B, 1'b0, "R7");
        do_read(1'b1, 24'h00400A, 1'b1, "R10");
        cfg_tacc = '0;
        do_read(1'b0, 24'h005000, 1'b0, "R10");
        cfg_tacc = 8'd6; cfg_tpacc = 8'd3;

        // R1: reset mid-stream drops chip enable and the open page
        do_read(1'b0, 24'h006000, 1'b0, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        check(fl_ce_n == 1'b1 && rsp_valid == 1'b0, "R1", "reset releases ce",
              {fl_ce_n, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(1'b0, 24'h006002, 1'b0, "R1");
        do_read(1'b0, 24'h006004, 1'b1, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule